// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between an integer core and a word-wide synchronous data memory. For every request it adds a sign-extended 16-bit displacement to a base value, checks that the resulting byte address suits the access size, and drives the word address, the four byte-lane write enables and the lane-placed write data toward memory in the same cycle.

Loads return through the same unit. The unit keeps a small tag per outstanding read (lane, size, extension kind) so that, when the memory's read data arrives, it can pick the addressed byte, halfword or word and widen it to 32 bits with either sign or zero fill. A misaligned request never reaches memory and instead raises a flag during the request cycle.

Lane placement is big-endian: the byte at word offset 0 occupies bits 31:24 of the memory word and offset 3 occupies bits 7:0. Sub-word stores take only the low-order bytes of the source register.

Top module: `mem_align_unit`

## Requirements
- R1: The byte address equals base plus the 16-bit displacement sign-extended to 32 bits; an accepted request drives `mem_addr` with bits 31:2 of that address in the same cycle.
- R2: The operation code is {store, unsigned, size[1:0]} with size 00 byte, 01 halfword, 10 word (11 behaves as word); a word access whose address bits 1:0 are not 00 raises `misalign` in the request cycle.
- R3: A halfword access with address bit 0 set raises `misalign`; whenever `misalign` is high, `mem_req` is low, `mem_we` is 0000 and no load result follows.
- R4: A byte store asserts exactly one write enable; `mem_we[3]` covers bits 31:24 (address offset 0) down to `mem_we[0]` covering bits 7:0 (offset 3), and the enabled lane carries bits 7:0 of the store value.
- R5: A halfword store enables lanes 1100 for offset 0 and 0011 for offset 2, placing bits 15:8 of the store value at the lower address and bits 7:0 at the higher address.
- R6: An aligned word store enables all four lanes and writes the store value unchanged, its bits 31:24 at the lowest address.
- R7: Signed byte and halfword loads copy the sign bit of the loaded item into every upper bit of `load_data`.
- R8: Unsigned byte and halfword loads fill every upper bit of `load_data` with zeros.
- R9: Loads select lanes big-endian: the byte at the lowest address comes from memory bits 31:24, and a halfword at offset 0 comes from bits 31:16.
- R10: `load_valid` rises exactly RD_LAT cycles (default 1) after an accepted load and is never raised by a store or a rejected request; stores never assert write enables on loads.
- R11: After reset, `load_valid` and `mem_req` are low while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | {store, unsigned, size[1:0]} |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Store source register |
| misalign | output | 1 | Request rejected for alignment |
| mem_req | output | 1 | Memory access strobe |
| mem_addr | output | 30 | Word address to memory |
| mem_we | output | 4 | Per-lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rdata | input | 32 | Memory read word, RD_LAT cycles after request |
| load_valid | output | 1 | Load result present |
| load_data | output | 32 | Extended load result |

## Verification
Byte loads are tried at all four offsets against memory bytes with both sign bit states, once signed and once unsigned, which separates lane selection from the extension rule. Halfword and word loads at every legal offset, and stores of each size followed by a word read-back, show whether bytes land in big-endian order and whether untouched lanes survive. Word addresses at offsets 1 to 3 and halfword addresses at offsets 1 and 3, including a misaligned store followed by a read-back, show that rejection blocks both the write and the load result. Negative displacements and back-to-back loads check the address adder's sign handling and the tag pipeline.

// File: rtl/mau_pkg.sv
package mau_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } mau_size_e;

    localparam int unsigned OP_W      = 4;
    localparam int unsigned OP_STORE  = 3;
    localparam int unsigned OP_UNSIGN = 2;

endpackage

// File: rtl/mau_addr_gen.sv
module mau_addr_gen
    import mau_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned LANE_W = 2
) (
    input  logic              req_valid,
    input  mau_size_e         size,
    input  logic [XLEN-1:0]   base,
    input  logic [OFF_W-1:0]  offset,
    output logic [XLEN-1:0]   eff_addr,
    output logic [LANE_W-1:0] lane,
    output logic              misalign
);
    logic bad_align;

    always_comb begin
        eff_addr = base + {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
        lane     = eff_addr[LANE_W-1:0];
        unique case (size)
            SZ_BYTE: bad_align = 1'b0;
            SZ_HALF: bad_align = eff_addr[0];
            default: bad_align = |eff_addr[LANE_W-1:0];
        endcase
        misalign = req_valid && bad_align;
    end
endmodule

// File: rtl/mau_store_lane.sv
module mau_store_lane
    import mau_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned LANES  = XLEN / 8,
    parameter int unsigned LANE_W = $clog2(LANES)
) (
    input  logic              do_store,
    input  mau_size_e         size,
    input  logic [LANE_W-1:0] lane,
    input  logic [XLEN-1:0]   store_data,
    output logic [LANES-1:0]  we,
    output logic [XLEN-1:0]   wdata
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [7:0] byte_w;
        logic       en;

        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    byte_w = store_data[7:0];
                    en     = (lane == LANE_W'(k));
                end
                SZ_HALF: begin
                    byte_w = ((k % 2) == 0) ? store_data[15:8] : store_data[7:0];
                    en     = (lane[LANE_W-1:1] == (LANE_W-1)'(k / 2));
                end
                default: begin
                    byte_w = store_data[XLEN-1-8*k -: 8];
                    en     = 1'b1;
                end
            endcase
        end

        assign wdata[XLEN-1-8*k -: 8] = byte_w;
        assign we[LANES-1-k]          = en && do_store;
    end
endmodule

// File: rtl/mau_load_extract.sv
module mau_load_extract
    import mau_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned LANE_W = 2
) (
    input  logic              valid,
    input  mau_size_e         size,
    input  logic [LANE_W-1:0] lane,
    input  logic              zext,
    input  logic [XLEN-1:0]   rdata,
    output logic [XLEN-1:0]   data
);
    logic [XLEN-1:0] shifted;
    logic [7:0]      item_b;
    logic [15:0]     item_h;

    always_comb begin
        shifted = rdata << {lane, 3'b000};
        item_b  = shifted[XLEN-1 -: 8];
        item_h  = shifted[XLEN-1 -: 16];
        unique case (size)
            SZ_BYTE: data = {{(XLEN-8){~zext & item_b[7]}}, item_b};
            SZ_HALF: data = {{(XLEN-16){~zext & item_h[15]}}, item_h};
            default: data = rdata;
        endcase
        if (!valid) begin
            data = '0;
        end
    end
endmodule

// File: rtl/mem_align_unit.sv
module mem_align_unit
    import mau_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned RD_LAT = 1,
    localparam int unsigned LANES   = XLEN / 8,
    localparam int unsigned LANE_W  = $clog2(LANES),
    localparam int unsigned WADDR_W = XLEN - LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [OP_W-1:0]    req_op,
    input  logic [XLEN-1:0]    base,
    input  logic [OFF_W-1:0]   offset,
    input  logic [XLEN-1:0]    store_data,
    output logic               misalign,
    output logic               mem_req,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]   mem_we,
    output logic [XLEN-1:0]    mem_wdata,
    input  logic [XLEN-1:0]    mem_rdata,
    output logic               load_valid,
    output logic [XLEN-1:0]    load_data
);
    typedef struct packed {
        logic              valid;
        logic [LANE_W-1:0] lane;
        mau_size_e         size;
        logic              zext;
    } rd_tag_t;

    typedef struct packed {
        rd_tag_t [RD_LAT-1:0] pipe;
    } state_t;

    state_t state_d, state_q;

    mau_size_e         req_size;
    logic              is_store;
    logic [XLEN-1:0]   eff_addr;
    logic [LANE_W-1:0] lane;
    rd_tag_t           out_tag;

    assign req_size = mau_size_e'(req_op[1:0]);
    assign is_store = req_op[OP_STORE];

    mau_addr_gen #(
        .XLEN  (XLEN),
        .OFF_W (OFF_W),
        .LANE_W(LANE_W)
    ) u_addr (
        .req_valid(req_valid),
        .size     (req_size),
        .base     (base),
        .offset   (offset),
        .eff_addr (eff_addr),
        .lane     (lane),
        .misalign (misalign)
    );

    assign mem_req  = req_valid && !misalign;
    assign mem_addr = eff_addr[XLEN-1:LANE_W];

    mau_store_lane #(
        .XLEN  (XLEN),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_store (
        .do_store  (mem_req && is_store),
        .size      (req_size),
        .lane      (lane),
        .store_data(store_data),
        .we        (mem_we),
        .wdata     (mem_wdata)
    );

    always_comb begin
        state_d = state_q;
        state_d.pipe[0].valid = mem_req && !is_store;
        state_d.pipe[0].lane  = lane;
        state_d.pipe[0].size  = req_size;
        state_d.pipe[0].zext  = req_op[OP_UNSIGN];
        for (int i = 1; i < RD_LAT; i++) begin
            state_d.pipe[i] = state_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_tag    = state_q.pipe[RD_LAT-1];
    assign load_valid = out_tag.valid;

    mau_load_extract #(
        .XLEN  (XLEN),
        .LANE_W(LANE_W)
    ) u_load (
        .valid(out_tag.valid),
        .size (out_tag.size),
        .lane (out_tag.lane),
        .zext (out_tag.zext),
        .rdata(mem_rdata),
        .data (load_data)
    );
endmodule

// File: rtl/mau_checker.sv
module mau_checker
    import mau_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned RD_LAT = 1,
    localparam int unsigned LANES   = XLEN / 8,
    localparam int unsigned LANE_W  = $clog2(LANES),
    localparam int unsigned WADDR_W = XLEN - LANE_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [OP_W-1:0]    req_op,
    input logic [XLEN-1:0]    base,
    input logic [OFF_W-1:0]   offset,
    input logic               misalign,
    input logic               mem_req,
    input logic [WADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]   mem_we,
    input logic               load_valid
);
    logic [XLEN-1:0]   ea;
    logic [RD_LAT-1:0] rd_sh_q;

    assign ea = base + {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_sh_q <= '0;
        end else begin
            rd_sh_q <= {rd_sh_q, mem_req && !req_op[OP_STORE]};
        end
    end

    a_r1_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == ea[XLEN-1:LANE_W]));

    a_r2_word_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[1] && (ea[LANE_W-1:0] != '0)) |-> misalign);

    a_r3_quiet_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_req && (mem_we == '0)));

    a_r3_half_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op[1:0] == 2'b01) && ea[0]) |-> misalign);

    a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_op[OP_STORE] && (req_op[1:0] == 2'b00)) |-> ($countones(mem_we) == 1));

    a_r10_valid_timing: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid == rd_sh_q[RD_LAT-1]);

    a_r10_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !req_op[OP_STORE]) |-> (mem_we == '0));
endmodule

bind mem_align_unit mau_checker #(
    .XLEN  (XLEN),
    .OFF_W (OFF_W),
    .RD_LAT(RD_LAT)
) u_mau_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .base      (base),
    .offset    (offset),
    .misalign  (misalign),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .load_valid(load_valid)
);

// File: tb/tb_mem_align_unit.sv
`timescale 1ns/1ps
module tb_mem_align_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = 4'd0;
    logic [31:0] base = 32'd0;
    logic [15:0] offset = 16'd0;
    logic [31:0] store_data = 32'd0;
    logic        misalign, mem_req, load_valid;
    logic [29:0] mem_addr;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata, load_data;
    logic [31:0] mem_rdata = 32'd0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] dmem [64];
    logic [7:0]  ref_mem [256];

    always #4 clk = ~clk;

    mem_align_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .base(base), .offset(offset), .store_data(store_data),
        .misalign(misalign), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .load_valid(load_valid), .load_data(load_data)
    );

    // word-wide synchronous memory, one cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we != 4'b0000) begin
                for (int k = 0; k < 4; k++)
                    if (mem_we[3-k]) dmem[mem_addr[5:0]][31-8*k -: 8] <= mem_wdata[31-8*k -: 8];
            end else begin
                mem_rdata <= dmem[mem_addr[5:0]];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one request: drive, compare request-cycle outputs, then the load result one cycle later
    task automatic do_op(input bit st, input bit uns, input logic [1:0] sz,
                         input logic [31:0] b, input logic [15:0] off,
                         input logic [31:0] sd, input string req);
        logic [31:0] ea, item, expv;
        int n, o;
        bit bad;
        logic [3:0] exp_we;
        req_valid = 1'b1; req_op = {st, uns, sz}; base = b; offset = off; store_data = sd;
        ea = b + {{16{off[15]}}, off};
        n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        o = int'(ea[1:0]);
        bad = (o % n) != 0;
        exp_we = 4'b0000;
        if (st && !bad) for (int j = 0; j < n; j++) exp_we[3-(o+j)] = 1'b1;
        #1;
        chk(misalign == bad, {req, " misalign"}, 32'(misalign), 32'(bad));
        chk(mem_req == !bad, {req, " mem_req"}, 32'(mem_req), 32'(!bad));
        chk(mem_we == exp_we, {req, " mem_we"}, 32'(mem_we), 32'(exp_we));
        if (!bad) begin
            chk(mem_addr == ea[31:2], {req, " R1 mem_addr"}, 32'(mem_addr), 32'(ea[31:2]));
            if (st) for (int j = 0; j < n; j++)
                chk(mem_wdata[31-8*(o+j) -: 8] == sd[8*(n-1-j) +: 8], {req, " wdata lane"},
                    32'(mem_wdata[31-8*(o+j) -: 8]), 32'(sd[8*(n-1-j) +: 8]));
        end
        item = 32'd0;
        for (int j = 0; j < n; j++) item = (item << 8) | 32'(ref_mem[8'(ea + 32'(j))]);
        if (n == 1) expv = uns ? item : {{24{item[7]}}, item[7:0]};
        else if (n == 2) expv = uns ? item : {{16{item[15]}}, item[15:0]};
        else expv = item;
        @(posedge clk);
        if (st && !bad) for (int j = 0; j < n; j++) ref_mem[8'(ea + 32'(j))] = sd[8*(n-1-j) +: 8];
        @(negedge clk);
        #1;
        chk(load_valid == (!st && !bad), {req, " R10 load_valid"}, 32'(load_valid), 32'(!st && !bad));
        if (!st && !bad) chk(load_data == expv, {req, " load_data"}, load_data, expv);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) ref_mem[a] = 8'((a * 37 + 131) & 255);
        for (int w = 0; w < 64; w++)
            dmem[w] = {ref_mem[4*w], ref_mem[4*w+1], ref_mem[4*w+2], ref_mem[4*w+3]};
        repeat (3) @(negedge clk);
        #1;
        chk(load_valid == 1'b0, "R11 reset load_valid", 32'(load_valid), 32'd0);
        chk(mem_req == 1'b0, "R11 reset mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        do_op(0, 0, 2'b10, 32'h0000_0040, 16'h0000, 0, "R9 R6 word load");
        for (int k = 0; k < 4; k++) begin
            do_op(0, 0, 2'b00, 32'h0000_0010, 16'(k), 0, "R7 R9 signed byte load");
            do_op(0, 1, 2'b00, 32'h0000_0010, 16'(k), 0, "R8 R9 unsigned byte load");
            do_op(0, 0, 2'b00, 32'h0000_0014, 16'(k), 0, "R7 signed byte load b");
        end
        for (int k = 0; k < 4; k += 2) begin
            do_op(0, 0, 2'b01, 32'h0000_0020, 16'(k), 0, "R7 R9 signed half load");
            do_op(0, 1, 2'b01, 32'h0000_0024, 16'(k), 0, "R8 unsigned half load");
        end
        do_op(0, 0, 2'b10, 32'h0000_0080, 16'hFFF8, 0, "R1 negative offset load");
        for (int k = 0; k < 4; k++)
            do_op(1, 0, 2'b00, 32'h0000_0030, 16'(k), 32'hABCD_EF00 | 32'(k + 8'h90), "R4 byte store");
        do_op(0, 0, 2'b10, 32'h0000_0030, 16'h0000, 0, "R4 byte store readback");
        do_op(1, 0, 2'b01, 32'h0000_0034, 16'h0000, 32'h1234_5678, "R5 half store off0");
        do_op(1, 0, 2'b01, 32'h0000_0034, 16'h0002, 32'h9ABC_DEF0, "R5 half store off2");
        do_op(0, 0, 2'b10, 32'h0000_0034, 16'h0000, 0, "R5 half store readback");
        do_op(1, 0, 2'b10, 32'h0000_0038, 16'h0000, 32'hCAFE_0123, "R6 word store");
        do_op(0, 1, 2'b00, 32'h0000_0038, 16'h0000, 0, "R6 word store msb at low addr");
        for (int k = 1; k < 4; k++)
            do_op(0, 0, 2'b10, 32'h0000_0040, 16'(k), 0, "R2 misaligned word load");
        do_op(1, 0, 2'b01, 32'h0000_003C, 16'h0001, 32'h5555_AAAA, "R3 misaligned half store");
        do_op(1, 0, 2'b10, 32'h0000_003C, 16'h0003, 32'h5555_AAAA, "R3 misaligned word store");
        do_op(0, 0, 2'b10, 32'h0000_003C, 16'h0000, 0, "R3 readback after rejected stores");
        do_op(0, 1, 2'b01, 32'h0000_0050, 16'h0003, 0, "R3 misaligned half load");
        do_op(0, 0, 2'b11, 32'h0000_0044, 16'h0000, 0, "R2 size 11 as word");
        do_op(0, 0, 2'b11, 32'h0000_0044, 16'h0002, 0, "R2 size 11 misaligned");
        for (int k = 0; k < 8; k++)
            do_op(0, k[0], 2'(k % 3), 32'h0000_0060 + 32'(4 * k), 16'hFFFC, 0, "R10 back-to-back loads");
        req_valid = 1'b0;
        #1;
        chk(mem_req == 1'b0, "R11 idle mem_req", 32'(mem_req), 32'd0);
        @(negedge clk);
        #1;
        chk(load_valid == 1'b0, "R10 idle load_valid", 32'(load_valid), 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule